// File: doc/BRIEF.md
# Key-Protected Pin Function Lock

This register block decides whether each of four guarded pins serves the debug port or general-purpose I/O. Out of reset every pin belongs to the debug port. Software can hand a pin to general-purpose use only in three steps. First it writes a 32-bit key to the lock register. Next it sets that pin's bit in the commit register. Only then does it write the function-select register. A select write leaves alone every pin whose commit bit is clear. Any non-key value written to the lock register closes the block again.

The registers sit behind a small word-addressed bus: address, write data, write strobe, combinational read data. The port also has a clock-enable input. The block ignores bus accesses until a ready flag, derived from that enable, has come up.

Top module: `pin_func_guard`

## Requirements
- R1: After synchronous reset, `pin_is_debug` is all ones, the lock register reads 1, the commit register reads 0 and the select register reads 0 (once ready).
- R2: `port_ready` goes to 1 on the second rising clock edge at which `port_clk_en` is sampled high. While `port_ready` is 0, writes have no effect and `bus_rdata` is 0.
- R3: The lock register (address 0) reads 1 while the block is locked and 0 while it is unlocked.
- R4: Writing 0x4C4F434B to address 0 unlocks the block. Any other value, including one differing in a single bit, leaves it locked.
- R5: While the block is unlocked, writing any non-key value to address 0 locks it again.
- R6: The commit register is at address 1. While the block is unlocked, a write stores `bus_wdata[3:0]` and ignores the upper bits. While it is locked, writes are ignored and the stored value is kept, including across a relock.
- R7: The select register is at address 2, with bit n = 1 meaning pin n is general-purpose. While the block is unlocked, a write updates bit n only when commit bit n is 1. While it is locked, every select write is ignored.
- R8: `pin_is_debug[n]` is the inverse of select bit n and follows it on the same edge that updates the register.
- R9: A reset asserted in the middle of operation restores the R1 state and also clears `port_ready`.
- R10: Address 3 is unmapped. It reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_clk_en | input | 1 | Port clock enable |
| port_ready | output | 1 | Port ready status; bus is live when 1 |
| bus_addr | input | 2 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pin_is_debug | output | 4 | 1 = pin serves the debug port |

## Verification
Every register write takes effect on the rising edge that samples the strobe. Read data is combinational from the registers, so the bench reads back from the falling edge that follows a write, one timestep after setting the address. `pin_is_debug` is checked in that same half-cycle, because R8 allows it no extra latency. The ready flag is probed after exactly one and after exactly two enabled edges, which pins down the two-cycle delay. The bench sweeps all 16 commit masks against all 16 select values and predicts each result as `(d & m) | (prev & ~m)`.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int NUM_PINS = 4;
    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h4C4F434B;

    typedef enum logic [ADDR_W-1:0] {
        REG_LOCK   = 2'd0,
        REG_COMMIT = 2'd1,
        REG_FSEL   = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic wr_lock;
        logic wr_commit;
        logic wr_fsel;
    } wr_strobe_t;

    function automatic logic key_match(input logic [DATA_W-1:0] d);
        return d == UNLOCK_KEY;
    endfunction
endpackage

// File: rtl/pfl_ready_gate.sv
module pfl_ready_gate #(
    parameter int READY_DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_en_i,
    output logic ready_o
);
    logic [READY_DLY-1:0] stage_q;

    generate
        for (genvar i = 0; i < READY_DLY; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= 1'b0;
                    else     stage_q[i] <= clk_en_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= 1'b0;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign ready_o = stage_q[READY_DLY-1];

    // R2: ready only rises after the enable was seen
    a_r2_ready_follows_en: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> $past(clk_en_i));
endmodule

// File: rtl/pfl_lock_ctrl.sv
module pfl_lock_ctrl
    import pfl_pkg::*;
#(
    parameter int NP = NUM_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lock_i,
    input  logic              wr_commit_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              locked_o,
    output logic [NP-1:0]     commit_o
);
    logic          locked_q;
    logic [NP-1:0] commit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b1;
        end else if (wr_lock_i) begin
            locked_q <= !key_match(wdata_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_q <= '0;
        end else if (wr_commit_i && !locked_q) begin
            commit_q <= wdata_i[NP-1:0];
        end
    end

    assign locked_o = locked_q;
    assign commit_o = commit_q;

    // R4: unlocking only ever follows a key write
    a_r4_unlock_needs_key: assert property (@(posedge clk) disable iff (rst)
        $fell(locked_q) |-> $past(wr_lock_i && wdata_i == UNLOCK_KEY));
    // R6: commit bits frozen while locked
    a_r6_commit_frozen: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> $stable(commit_q));
endmodule

// File: rtl/pfl_fsel_reg.sv
module pfl_fsel_reg #(
    parameter int NP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  logic [NP-1:0] commit_i,
    input  logic [NP-1:0] wdata_i,
    output logic [NP-1:0] sel_o
);
    logic [NP-1:0] sel_q;

    generate
        for (genvar p = 0; p < NP; p++) begin : g_pin
            always_ff @(posedge clk) begin
                if (rst)                     sel_q[p] <= 1'b0;
                else if (wr_i && commit_i[p]) sel_q[p] <= wdata_i[p];
            end
        end
    endgenerate

    assign sel_o = sel_q;

    // R7: no change without an accepted write
    a_r7_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(sel_q));
    // R7: uncommitted pins never move
    a_r7_uncommitted_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sel_q ^ $past(sel_q)) & ~$past(commit_i)) == '0);
endmodule

// File: rtl/pin_func_guard.sv
module pin_func_guard
    import pfl_pkg::*;
#(
    parameter int READY_DLY = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                port_clk_en,
    output logic                port_ready,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] pin_is_debug
);
    reg_sel_e            sel;
    wr_strobe_t          stb;
    logic                locked;
    logic [NUM_PINS-1:0] commit;
    logic [NUM_PINS-1:0] fsel;

    pfl_ready_gate #(.READY_DLY(READY_DLY)) u_ready (
        .clk(clk), .rst(rst), .clk_en_i(port_clk_en), .ready_o(port_ready)
    );

    assign sel = reg_sel_e'(bus_addr);

    always_comb begin
        stb           = '0;
        stb.wr_lock   = port_ready && bus_wr && (sel == REG_LOCK);
        stb.wr_commit = port_ready && bus_wr && (sel == REG_COMMIT);
        stb.wr_fsel   = port_ready && bus_wr && (sel == REG_FSEL) && !locked;
    end

    pfl_lock_ctrl #(.NP(NUM_PINS)) u_lock (
        .clk(clk), .rst(rst),
        .wr_lock_i(stb.wr_lock), .wr_commit_i(stb.wr_commit),
        .wdata_i(bus_wdata), .locked_o(locked), .commit_o(commit)
    );

    pfl_fsel_reg #(.NP(NUM_PINS)) u_fsel (
        .clk(clk), .rst(rst), .wr_i(stb.wr_fsel), .commit_i(commit),
        .wdata_i(bus_wdata[NUM_PINS-1:0]), .sel_o(fsel)
    );

    always_comb begin
        bus_rdata = '0;
        if (port_ready) begin
            unique case (sel)
                REG_LOCK:   bus_rdata[0]          = locked;
                REG_COMMIT: bus_rdata[NUM_PINS-1:0] = commit;
                REG_FSEL:   bus_rdata[NUM_PINS-1:0] = fsel;
                default:    bus_rdata             = '0;
            endcase
        end
    end

    assign pin_is_debug = ~fsel;

    // R1 / R9: the cycle after reset all pins are debug
    a_r1_reset_debug: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_is_debug == '1 && !port_ready));
    // R7: pins only leave debug while unlocked
    a_r7_locked_pins_hold: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(pin_is_debug));
    // R2: no register changes before ready
    a_r2_gate_blocks: assert property (@(posedge clk) disable iff (rst)
        !port_ready |=> ($stable(commit) && $stable(fsel)));
endmodule

// File: tb/sim_pin_func_guard.sv
module sim_pin_func_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic        rdy;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  dbg;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [31:0] KEY = 32'h4C4F434B;

    always #2.5 clk = ~clk;

    pin_func_guard u0 (
        .clk(clk), .rst(rst), .port_clk_en(en), .port_ready(rdy),
        .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .pin_is_debug(dbg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        addr = a; wr = 1'b0;
        #1 d = rdata;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [3:0]  expsel;
        expsel = 4'h0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 debug after reset", {28'h0, dbg}, 32'hF);

        // R2: gate closed, write ignored, reads zero
        wr_reg(2'd0, KEY);
        rd_reg(2'd0, v); chk("R2 read zero not ready", v, 0);
        en = 1'b1;
        @(negedge clk);
        chk("R2 not ready after one edge", {31'h0, rdy}, 0);
        rd_reg(2'd0, v); chk("R2 read zero after one edge", v, 0);
        @(negedge clk);
        chk("R2 ready after two edges", {31'h0, rdy}, 1);
        rd_reg(2'd0, v); chk("R2 early key write ignored / R3 locked", v, 1);
        rd_reg(2'd1, v); chk("R1 commit zero", v, 0);
        rd_reg(2'd2, v); chk("R1 select zero", v, 0);

        // R7: select write while locked
        wr_reg(2'd2, 32'hF);
        chk("R7 locked select ignored", {28'h0, dbg}, 32'hF);

        // R4 wrong keys
        wr_reg(2'd0, KEY ^ 32'h1);
        rd_reg(2'd0, v); chk("R4 wrong key low bit", v, 1);
        wr_reg(2'd0, KEY ^ 32'h8000_0000);
        rd_reg(2'd0, v); chk("R4 wrong key high bit", v, 1);
        wr_reg(2'd1, 32'hF);
        rd_reg(2'd1, v); chk("R6 commit locked ignored", v, 0);
        wr_reg(2'd0, KEY);
        rd_reg(2'd0, v); chk("R3 R4 unlocked reads 0", v, 0);

        // R10 unmapped
        wr_reg(2'd3, 32'hFFFF_FFFF);
        rd_reg(2'd3, v); chk("R10 unmapped reads 0", v, 0);
        rd_reg(2'd0, v); chk("R10 lock untouched", v, 0);

        for (int m = 0; m < 16; m++) begin
            wr_reg(2'd0, KEY);
            wr_reg(2'd1, {28'hABCDEF1, 4'(m)});
            rd_reg(2'd1, v); chk("R6 commit stores low bits", v, 32'(m));
            for (int d = 0; d < 16; d++) begin
                wr_reg(2'd2, {28'hFFFFFFF, 4'(d)});
                expsel = (4'(d) & 4'(m)) | (expsel & ~4'(m));
                chk("R8 pin follows select", {28'h0, dbg}, {28'h0, ~expsel});
                rd_reg(2'd2, v); chk("R7 masked select", v, {28'h0, expsel});
            end
            wr_reg(2'd0, 32'h0);
            rd_reg(2'd0, v); chk("R5 relock", v, 1);
            rd_reg(2'd1, v); chk("R6 commit kept on relock", v, 32'(m));
            wr_reg(2'd1, 32'(~m));
            rd_reg(2'd1, v); chk("R6 commit write locked ignored", v, 32'(m));
            wr_reg(2'd2, {28'h0, ~expsel});
            chk("R7 select after relock ignored", {28'h0, dbg}, {28'h0, ~expsel});
        end

        // R9 mid-operation reset
        wr_reg(2'd0, KEY);
        wr_reg(2'd1, 32'hF);
        wr_reg(2'd2, 32'h5);
        chk("R8 pins 0 2 general", {28'h0, dbg}, 32'hA);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R9 pins debug", {28'h0, dbg}, 32'hF);
        chk("R9 ready cleared", {31'h0, rdy}, 0);
        rd_reg(2'd0, v); chk("R9 read zero not ready", v, 0);
        repeat (2) @(negedge clk);
        rd_reg(2'd0, v); chk("R9 locked", v, 1);
        rd_reg(2'd1, v); chk("R9 commit cleared", v, 0);
        rd_reg(2'd2, v); chk("R9 select cleared", v, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule